// File: doc/BRIEF.md
# Regular Conversion Group Sequencer

This block walks a programmable list of up to sixteen ranks, each naming one of eighteen input channels, and issues one conversion request per rank to a converter core. The request carries the channel number and that channel's sample-time code. The core later answers with a one-cycle done pulse and a 12-bit sample. The block latches the sample into a 16-bit result word, aligned right or left, and raises the start and end-of-conversion flags.

Software sets the block up through a simple synchronous write port and a combinational read port. It chooses single-rank or scan operation, continuous restart, and a discontinuous mode. In discontinuous mode each trigger converts only the next sub-group of ranks. A conversion pass is started by a self-clearing software start bit or by a rising edge on an external trigger pin, and that pin is honoured only while its enable bit is set.

The request toward the core is a valid/ready stream. The block holds `req_valid` with a stable channel and sample-time code until the core asserts `req_ready`. It never has more than one request outstanding, so the core applies back-pressure simply by leaving `req_ready` low. The done/data return path has no back-pressure: every done pulse is taken.

Top module: `rank_sequencer`

## Requirements
- R1: After reset every register reads 0, `req_valid` is low, and `start_flag`, `eoc_flag` and `result_data` are 0.
- R2: The sequence registers sit at address 2 (ranks 1–6), 3 (ranks 7–12) and 4 (ranks 13–16). Within its register, rank r uses bits 5·(r−first)+4 : 5·(r−first). The channel presented on `req_chan` for a rank is that 5-bit field.
- R3: `req_stime` is the 3-bit code of the requested channel. Channels 0–9 sit in address 5 at bits 3·c+2 : 3·c, and channels 10–17 in address 6 at bits 3·(c−10)+2 : 3·(c−10). Channel numbers above 17 give code 0.
- R4: The length field is bits 23:20 of address 4 and holds N−1. With the scan bit (control bit 0) clear, a pass converts rank 1 only. With it set, a pass converts ranks 1..N in order.
- R5: When the continuous bit (control bit 1) is set outside discontinuous mode, the sequence restarts at rank 1 after its last rank with no new trigger. If the bit is cleared during a pass, that pass completes and the block stops.
- R6: When the discontinuous bit (control bit 2) is set, each trigger converts the next sub-group over ranks 1..N. The sub-group holds count ranks, where control bits 5:3 hold count−1. A final sub-group is shorter when fewer ranks remain, and the trigger after it wraps back to rank 1. The continuous bit has no effect in this mode.
- R7: Writing 1 to control bit 8 requests a software start. That bit reads back 0 once the block has taken the trigger. A rising edge on `ext_trig` starts a pass only while control bit 6 is 1, and is ignored otherwise.
- R8: `req_valid` with `req_chan` and `req_stime` stays asserted and unchanged until `req_ready`. After a handshake, no new request is made until `conv_done`.
- R9: On `conv_done` the result word takes `conv_data` in bits 11:0 when control bit 7 is 0, and in bits 15:4 when it is 1. It changes at no other time and reads back at address 7.
- R10: Status address 1 holds end-of-conversion in bit 0, set by `conv_done`, and start in bit 1, set at each request handshake. Writing 0 to a status bit clears it, writing 1 leaves it unchanged, and a hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 30 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 30 | Register read data (combinational) |
| ext_trig | input | 1 | External trigger, rising edge used |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Core accepts the request |
| req_chan | output | 5 | Channel to convert |
| req_stime | output | 3 | Sample-time code of that channel |
| conv_done | input | 1 | One-cycle pulse: sample available |
| conv_data | input | 12 | Converted sample |
| result_data | output | 16 | Latched, aligned result word |
| start_flag | output | 1 | Start status flag |
| eoc_flag | output | 1 | End-of-conversion status flag |

## Verification
The hardest case to reach from the ports is the continuous bit being cleared while a pass is in flight. The block must finish exactly that pass and then fall silent. The stimulus counts request handshakes and clears the bit while the fifth conversion is still in the core, which is held busy for several cycles. The request count must then settle at exactly six. The discontinuous wrap-around is driven through a length of seven with sub-groups of three, so the third trigger yields a one-rank sub-group and the fourth starts over at rank 1. The continuous bit stays set throughout to show that it is ignored in that mode.

// File: rtl/rank_seq_pkg.sv
package rank_seq_pkg;
  localparam int CH_W          = 5;
  localparam int NUM_CH        = 18;
  localparam int RANK_N        = 16;
  localparam int RANKS_PER_REG = 6;
  localparam int STIME_W       = 3;
  localparam int CH_PER_SMPREG = 10;
  localparam int DISC_W        = 3;
  localparam int LEN_W         = 4;
  localparam int LEN_LSB       = 20;
  localparam int ADDR_W        = 4;
  localparam int REG_W         = CH_W * RANKS_PER_REG;
  localparam int IDX_W         = $clog2(RANK_N);

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SEQA  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SEQB  = 4'd3;
  localparam logic [ADDR_W-1:0] A_SEQC  = 4'd4;
  localparam logic [ADDR_W-1:0] A_SMPA  = 4'd5;
  localparam logic [ADDR_W-1:0] A_SMPB  = 4'd6;
  localparam logic [ADDR_W-1:0] A_DATA  = 4'd7;

  // control word bit positions
  localparam int C_SCAN  = 0;
  localparam int C_CONT  = 1;
  localparam int C_DISC  = 2;
  localparam int C_NUM   = 3;
  localparam int C_EXTEN = 6;
  localparam int C_ALIGN = 7;
  localparam int C_SWST  = 8;
  localparam int CTRL_W  = 9;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_WAIT
  } sq_state_e;
endpackage

// File: rtl/rank_seq_regs.sv
module rank_seq_regs
  import rank_seq_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [REG_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [REG_W-1:0]            rd_data,
  input  logic                        sw_taken,
  input  logic                        set_start,
  input  logic                        set_eoc,
  input  logic [OUT_W-1:0]            result_word,
  output logic                        cfg_scan,
  output logic                        cfg_cont,
  output logic                        cfg_disc,
  output logic [DISC_W-1:0]           cfg_num,
  output logic                        cfg_exten,
  output logic                        cfg_align,
  output logic                        sw_pending,
  output logic [LEN_W-1:0]            cfg_len,
  output logic [RANK_N*CH_W-1:0]      rank_vec,
  output logic [NUM_CH*STIME_W-1:0]   stime_vec,
  output logic                        start_q,
  output logic                        eoc_q
);
  localparam int SEQC_W = LEN_LSB + LEN_W;
  localparam int SMPB_W = (NUM_CH - CH_PER_SMPREG) * STIME_W;
  localparam int SMPA_W = CH_PER_SMPREG * STIME_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [REG_W-1:0]  seqa_q, seqb_q;
  logic [SEQC_W-1:0] seqc_q;
  logic [SMPA_W-1:0] smpa_q;
  logic [SMPB_W-1:0] smpb_q;

  logic wr_stat;
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      seqa_q  <= '0;
      seqb_q  <= '0;
      seqc_q  <= '0;
      smpa_q  <= '0;
      smpb_q  <= '0;
      start_q <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        ctrl_q <= wr_data[CTRL_W-1:0];
      end else if (sw_taken) begin
        ctrl_q[C_SWST] <= 1'b0;
      end
      if (wr_en && wr_addr == A_SEQA) seqa_q <= wr_data;
      if (wr_en && wr_addr == A_SEQB) seqb_q <= wr_data;
      if (wr_en && wr_addr == A_SEQC) seqc_q <= wr_data[SEQC_W-1:0];
      if (wr_en && wr_addr == A_SMPA) smpa_q <= wr_data[SMPA_W-1:0];
      if (wr_en && wr_addr == A_SMPB) smpb_q <= wr_data[SMPB_W-1:0];
      // write-zero-to-clear; a hardware set in the same cycle dominates
      start_q <= set_start | (start_q & ~(wr_stat & ~wr_data[1]));
      eoc_q   <= set_eoc   | (eoc_q   & ~(wr_stat & ~wr_data[0]));
    end
  end

  assign cfg_scan   = ctrl_q[C_SCAN];
  assign cfg_cont   = ctrl_q[C_CONT];
  assign cfg_disc   = ctrl_q[C_DISC];
  assign cfg_num    = ctrl_q[C_NUM +: DISC_W];
  assign cfg_exten  = ctrl_q[C_EXTEN];
  assign cfg_align  = ctrl_q[C_ALIGN];
  assign sw_pending = ctrl_q[C_SWST];
  assign cfg_len    = seqc_q[LEN_LSB +: LEN_W];

  // unpack rank fields from the three sequence words
  for (genvar r = 0; r < RANK_N; r++) begin : g_rank
    if (r < RANKS_PER_REG) begin : g_a
      assign rank_vec[r*CH_W +: CH_W] = seqa_q[r*CH_W +: CH_W];
    end else if (r < 2*RANKS_PER_REG) begin : g_b
      assign rank_vec[r*CH_W +: CH_W] = seqb_q[(r-RANKS_PER_REG)*CH_W +: CH_W];
    end else begin : g_c
      assign rank_vec[r*CH_W +: CH_W] = seqc_q[(r-2*RANKS_PER_REG)*CH_W +: CH_W];
    end
  end

  // unpack per-channel sample-time codes from the two timing words
  for (genvar c = 0; c < NUM_CH; c++) begin : g_smp
    if (c < CH_PER_SMPREG) begin : g_lo
      assign stime_vec[c*STIME_W +: STIME_W] = smpa_q[c*STIME_W +: STIME_W];
    end else begin : g_hi
      assign stime_vec[c*STIME_W +: STIME_W] = smpb_q[(c-CH_PER_SMPREG)*STIME_W +: STIME_W];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data = REG_W'(ctrl_q);
      A_STAT: rd_data = REG_W'({start_q, eoc_q});
      A_SEQA: rd_data = seqa_q;
      A_SEQB: rd_data = seqb_q;
      A_SEQC: rd_data = REG_W'(seqc_q);
      A_SMPA: rd_data = REG_W'(smpa_q);
      A_SMPB: rd_data = REG_W'(smpb_q);
      A_DATA: rd_data = REG_W'(result_word);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rank_seq_ctrl.sv
module rank_seq_ctrl
  import rank_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_scan,
  input  logic                   cfg_cont,
  input  logic                   cfg_disc,
  input  logic [DISC_W-1:0]      cfg_num,
  input  logic                   cfg_exten,
  input  logic                   sw_pending,
  input  logic [LEN_W-1:0]       cfg_len,
  input  logic [RANK_N*CH_W-1:0] rank_vec,
  input  logic                   ext_trig,
  input  logic                   req_ready,
  input  logic                   conv_done,
  output logic                   req_valid,
  output logic [CH_W-1:0]        req_chan,
  output logic                   sw_taken,
  output logic                   accepted
);
  localparam int CNT_W = IDX_W + 1;
  localparam int GRP_W = DISC_W + 1;

  sq_state_e        state_q;
  logic [IDX_W-1:0] idx_q, disc_pos_q;
  logic [GRP_W-1:0] grp_left_q;
  logic             ext_q;

  logic             trig;
  logic [CNT_W-1:0] eff_len;
  logic             last_rank, grp_end;
  logic [IDX_W-1:0] first_idx;

  assign trig      = sw_pending | (cfg_exten & ext_trig & ~ext_q);
  assign eff_len   = (cfg_scan | cfg_disc) ? (CNT_W'(cfg_len) + 1'b1) : CNT_W'(1);
  assign last_rank = (CNT_W'(idx_q) + 1'b1) >= eff_len;
  assign grp_end   = last_rank | (cfg_disc & (grp_left_q == GRP_W'(1)));
  assign first_idx = (cfg_disc && (CNT_W'(disc_pos_q) < eff_len)) ? disc_pos_q : '0;

  assign req_valid = (state_q == SQ_REQ);
  assign req_chan  = rank_vec[idx_q*CH_W +: CH_W];
  assign accepted  = req_valid & req_ready;
  assign sw_taken  = (state_q == SQ_IDLE) & sw_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      idx_q      <= '0;
      disc_pos_q <= '0;
      grp_left_q <= '0;
      ext_q      <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      case (state_q)
        SQ_IDLE: begin
          if (trig) begin
            idx_q      <= first_idx;
            grp_left_q <= GRP_W'(cfg_num) + 1'b1;
            state_q    <= SQ_REQ;
          end
        end
        SQ_REQ: begin
          if (req_ready) state_q <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (conv_done) begin
            if (cfg_disc) begin
              if (grp_end) begin
                disc_pos_q <= last_rank ? '0 : idx_q + 1'b1;
                state_q    <= SQ_IDLE;
              end else begin
                idx_q      <= idx_q + 1'b1;
                grp_left_q <= grp_left_q - 1'b1;
                state_q    <= SQ_REQ;
              end
            end else if (last_rank) begin
              idx_q   <= '0;
              state_q <= cfg_cont ? SQ_REQ : SQ_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= SQ_REQ;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rank_seq_result.sv
module rank_seq_result #(
  parameter int SAMPLE_W = 12,
  parameter int SHIFT    = 4,
  localparam int OUT_W   = SAMPLE_W + SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_data,
  input  logic                align_left,
  output logic [OUT_W-1:0]    result_q
);
  logic [OUT_W-1:0] aligned;

  assign aligned = align_left ? {conv_data, {SHIFT{1'b0}}} : {{SHIFT{1'b0}}, conv_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else if (conv_done) result_q <= aligned;
  end
endmodule

// File: rtl/rank_sequencer.sv
module rank_sequencer
  import rank_seq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int SHIFT    = 4,
  localparam int OUT_W   = SAMPLE_W + SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  input  logic                ext_trig,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [CH_W-1:0]     req_chan,
  output logic [STIME_W-1:0]  req_stime,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_data,
  output logic [OUT_W-1:0]    result_data,
  output logic                start_flag,
  output logic                eoc_flag
);
  logic                       cfg_scan, cfg_cont, cfg_disc, cfg_exten, cfg_align;
  logic [DISC_W-1:0]          cfg_num;
  logic [LEN_W-1:0]           cfg_len;
  logic                       sw_pending, sw_taken, accepted;
  logic [RANK_N*CH_W-1:0]     rank_vec;
  logic [NUM_CH*STIME_W-1:0]  stime_vec;

  rank_seq_regs #(.OUT_W(OUT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sw_taken(sw_taken), .set_start(accepted), .set_eoc(conv_done),
    .result_word(result_data),
    .cfg_scan(cfg_scan), .cfg_cont(cfg_cont), .cfg_disc(cfg_disc),
    .cfg_num(cfg_num), .cfg_exten(cfg_exten), .cfg_align(cfg_align),
    .sw_pending(sw_pending), .cfg_len(cfg_len),
    .rank_vec(rank_vec), .stime_vec(stime_vec),
    .start_q(start_flag), .eoc_q(eoc_flag)
  );

  rank_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_scan(cfg_scan), .cfg_cont(cfg_cont), .cfg_disc(cfg_disc),
    .cfg_num(cfg_num), .cfg_exten(cfg_exten), .sw_pending(sw_pending),
    .cfg_len(cfg_len), .rank_vec(rank_vec), .ext_trig(ext_trig),
    .req_ready(req_ready), .conv_done(conv_done),
    .req_valid(req_valid), .req_chan(req_chan),
    .sw_taken(sw_taken), .accepted(accepted)
  );

  rank_seq_result #(.SAMPLE_W(SAMPLE_W), .SHIFT(SHIFT)) u_result (
    .clk(clk), .rst_n(rst_n),
    .conv_done(conv_done), .conv_data(conv_data),
    .align_left(cfg_align), .result_q(result_data)
  );

  // sample-time lookup for the channel being requested
  always_comb begin
    req_stime = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (req_chan == CH_W'(c)) req_stime = stime_vec[c*STIME_W +: STIME_W];
    end
  end
endmodule

// File: rtl/rank_sequencer_chk.sv
module rank_sequencer_chk #(
  parameter int CH_W    = 5,
  parameter int STIME_W = 3,
  parameter int OUT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [CH_W-1:0]    req_chan,
  input logic [STIME_W-1:0] req_stime,
  input logic               conv_done,
  input logic [OUT_W-1:0]   result_data,
  input logic               start_flag,
  input logic               eoc_flag
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_chan) && $stable(req_stime)); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R8

  AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> start_flag); // R10

  AST_EOC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> eoc_flag); // R10

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result_data)); // R9
endmodule

bind rank_sequencer rank_sequencer_chk #(.CH_W(5), .STIME_W(3), .OUT_W(16)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_chan(req_chan), .req_stime(req_stime), .conv_done(conv_done),
  .result_data(result_data), .start_flag(start_flag), .eoc_flag(eoc_flag)
);

// File: tb/rank_sequencer_tb_top.sv
`timescale 1ns/1ps
module rank_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [29:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [29:0] rd_data;
  logic        ext_trig = 1'b0;
  logic        req_valid, req_ready;
  logic [4:0]  req_chan;
  logic [2:0]  req_stime;
  logic        conv_done;
  logic [11:0] conv_data;
  logic [15:0] result_data;
  logic        start_flag, eoc_flag;

  always #2 clk = ~clk;

  rank_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_trig(ext_trig),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_stime(req_stime), .conv_done(conv_done), .conv_data(conv_data),
    .result_data(result_data), .start_flag(start_flag), .eoc_flag(eoc_flag)
  );

  typedef struct packed { logic [4:0] ch; logic [2:0] st; } exp_t;
  exp_t exp_q[$];

  int  checks = 0;
  int  fails = 0;
  int  hs_cnt = 0;
  bit  finished = 0;
  bit  align_tb = 0;
  logic [4:0] rank_tb [16];
  logic [2:0] stime_tb [18];

  // converter core model
  logic       busy, stall = 1'b0;
  int         lat;
  logic [4:0] cur;
  assign req_ready = !busy && !stall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; lat <= 0; conv_done <= 1'b0; conv_data <= '0; cur <= '0;
    end else begin
      conv_done <= 1'b0;
      if (busy) begin
        if (lat == 1) begin
          busy <= 1'b0; conv_done <= 1'b1; conv_data <= {cur, 7'h35};
        end else lat <= lat - 1;
      end else if (req_valid && req_ready) begin
        busy <= 1'b1; lat <= 6; cur <= req_chan;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit          res_pend = 0;
  logic [15:0] res_exp;
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_pend) begin
        chk(result_data == res_exp, "R9", "result word", result_data, res_exp);
        res_pend = 0;
      end
      if (conv_done) begin
        res_exp  = align_tb ? {conv_data, 4'b0} : {4'b0, conv_data};
        res_pend = 1;
      end
      if (req_valid && req_ready) begin
        hs_cnt++;
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected request", req_chan, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(req_chan == e.ch, "R2", "request channel", req_chan, e.ch);
          chk(req_stime == e.st, "R3", "sample-time code", req_stime, e.st);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [29:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [29:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic push_rank(input int r);
    exp_t e;
    e.ch = rank_tb[r];
    e.st = stime_tb[rank_tb[r]];
    exp_q.push_back(e);
  endtask

  task automatic wait_quiet();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (16) @(negedge clk);
  endtask

  function automatic logic [29:0] ctrl_word(bit scan, bit cont, bit disc, int num,
                                            bit ext, bit align, bit sw);
    logic [29:0] w;
    w = '0;
    w[0] = scan; w[1] = cont; w[2] = disc; w[5:3] = 3'(num);
    w[6] = ext; w[7] = align; w[8] = sw;
    return w;
  endfunction

  task automatic set_len(input int n);
    logic [29:0] w;
    w = '0;
    for (int i = 12; i < 16; i++) w[5*(i-12) +: 5] = rank_tb[i];
    w[23:20] = 4'(n - 1);
    wr(4'd4, w);
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [29:0] v, w;
    int base;
    rank_tb = '{5'd5, 5'd17, 5'd0, 5'd12, 5'd9, 5'd3, 5'd16, 5'd1,
                5'd14, 5'd2, 5'd11, 5'd7, 5'd4, 5'd15, 5'd6, 5'd13};
    for (int c = 0; c < 18; c++) stime_tb[c] = 3'((c * 3 + 1) % 8);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), v);
      chk(v == 0, "R1", "register after reset", v, 0);
    end
    chk(!req_valid && !start_flag && !eoc_flag && result_data == 0, "R1",
        "outputs after reset", {req_valid, start_flag, eoc_flag}, 0);

    // program ranks and sample times
    w = '0; for (int i = 0; i < 6; i++)  w[5*i +: 5] = rank_tb[i];     wr(4'd2, w);
    w = '0; for (int i = 6; i < 12; i++) w[5*(i-6) +: 5] = rank_tb[i]; wr(4'd3, w);
    w = '0; for (int c = 0; c < 10; c++) w[3*c +: 3] = stime_tb[c];     wr(4'd5, w);
    w = '0; for (int c = 10; c < 18; c++) w[3*(c-10) +: 3] = stime_tb[c]; wr(4'd6, w);
    set_len(4);
    rd(4'd6, v);
    chk(v[23:21] == stime_tb[17], "R3", "channel 17 timing field", v[23:21], stime_tb[17]);

    // R4: scan off converts rank 1 only, software start self-clears (R7)
    base = hs_cnt;
    push_rank(0);
    wr(4'd0, ctrl_word(0, 0, 0, 0, 0, 0, 1));
    wait_quiet();
    chk(hs_cnt == base + 1, "R4", "scan-off request count", hs_cnt - base, 1);
    rd(4'd0, v);
    chk(v[8] == 1'b0, "R7", "software start bit after use", v[8], 0);
    rd(4'd1, v);
    chk(v[1:0] == 2'b11, "R10", "status after conversion", v[1:0], 3);

    // R10: write 0 clears, write 1 keeps
    wr(4'd1, 30'h2);
    rd(4'd1, v);
    chk(v[1:0] == 2'b10, "R10", "status after clearing eoc", v[1:0], 2);
    wr(4'd1, 30'h0);
    rd(4'd1, v);
    chk(v[1:0] == 2'b00, "R10", "status after clearing both", v[1:0], 0);

    // R4: scan with length 4
    base = hs_cnt;
    for (int r = 0; r < 4; r++) push_rank(r);
    wr(4'd0, ctrl_word(1, 0, 0, 0, 0, 0, 1));
    wait_quiet();
    chk(hs_cnt == base + 4, "R4", "scan request count", hs_cnt - base, 4);

    // R7: external trigger ignored while disabled, then honoured
    wr(4'd1, 30'h0);
    set_len(3);
    wr(4'd0, ctrl_word(1, 0, 0, 0, 0, 0, 0));
    base = hs_cnt;
    pulse_ext();
    repeat (20) @(negedge clk);
    chk(hs_cnt == base && !start_flag, "R7", "disabled external trigger",
        hs_cnt - base, 0);
    wr(4'd0, ctrl_word(1, 0, 0, 0, 1, 0, 0));
    for (int r = 0; r < 3; r++) push_rank(r);
    pulse_ext();
    wait_quiet();
    chk(hs_cnt == base + 3, "R7", "enabled external trigger count", hs_cnt - base, 3);

    // R2/R4: full sixteen-rank scan
    set_len(16);
    base = hs_cnt;
    for (int r = 0; r < 16; r++) push_rank(r);
    wr(4'd0, ctrl_word(1, 0, 0, 0, 0, 0, 1));
    wait_quiet();
    chk(hs_cnt == base + 16, "R4", "sixteen-rank count", hs_cnt - base, 16);

    // R6: discontinuous, length 7, groups of 3, continuous bit set (no effect)
    set_len(7);
    base = hs_cnt;
    for (int r = 0; r < 3; r++) push_rank(r);
    wr(4'd0, ctrl_word(1, 1, 1, 2, 0, 0, 1));
    wait_quiet();
    chk(hs_cnt == base + 3, "R6", "first sub-group", hs_cnt - base, 3);
    for (int r = 3; r < 6; r++) push_rank(r);
    wr(4'd0, ctrl_word(1, 1, 1, 2, 0, 0, 1));
    wait_quiet();
    chk(hs_cnt == base + 6, "R6", "second sub-group", hs_cnt - base, 6);
    push_rank(6);
    wr(4'd0, ctrl_word(1, 1, 1, 2, 0, 0, 1));
    wait_quiet();
    chk(hs_cnt == base + 7, "R6", "short final sub-group", hs_cnt - base, 7);
    for (int r = 0; r < 3; r++) push_rank(r);
    wr(4'd0, ctrl_word(1, 1, 1, 2, 0, 0, 1));
    wait_quiet();
    chk(hs_cnt == base + 10, "R6", "wrap to rank 1", hs_cnt - base, 10);

    // R5: continuous restart, then clear the bit mid-pass
    set_len(2);
    base = hs_cnt;
    for (int k = 0; k < 3; k++) begin push_rank(0); push_rank(1); end
    wr(4'd0, ctrl_word(1, 1, 0, 0, 0, 0, 1));
    while (hs_cnt < base + 5) @(negedge clk);
    wr(4'd0, ctrl_word(1, 0, 0, 0, 0, 0, 0));
    wait_quiet();
    repeat (20) @(negedge clk);
    chk(hs_cnt == base + 6, "R5", "continuous stop count", hs_cnt - base, 6);

    // R9: left alignment
    align_tb = 1;
    push_rank(0);
    wr(4'd0, ctrl_word(0, 0, 0, 0, 0, 1, 1));
    wait_quiet();
    rd(4'd7, v);
    chk(v == {14'd0, 5'd5, 7'h35, 4'h0}, "R9", "left-aligned data readback", v,
        {5'd5, 7'h35, 4'h0});
    align_tb = 0;

    // R8: back-pressure holds the request
    base = hs_cnt;
    @(negedge clk); stall = 1'b1;
    push_rank(0);
    wr(4'd0, ctrl_word(0, 0, 0, 0, 0, 0, 1));
    repeat (10) @(negedge clk);
    chk(req_valid && req_chan == rank_tb[0], "R8", "request held under stall",
        {req_valid, req_chan}, {1'b1, rank_tb[0]});
    chk(hs_cnt == base, "R8", "no handshake while stalled", hs_cnt - base, 0);
    stall = 1'b0;
    wait_quiet();
    chk(hs_cnt == base + 1, "R8", "single handshake after stall", hs_cnt - base, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule